// File: doc/BRIEF.md
# Cursor-Addressed Pixel Register Interface

This block is the host-facing register set of a bitmap display controller. A host on a 16-bit bus reaches it through a 5-bit word offset. The block keeps an X/Y pixel cursor and a small set of drawing registers: a destination line, a drawing operation, a foreground/background colour pair and a display mode. It also keeps four palette banks. Each access offset in the low half of the map does two things. It adjusts the cursor by holding it, loading it from the bus or incrementing one axis. It also decides whether a pixel access to frame memory is started at the resulting cursor position.

Pixel accesses leave the block on a frame-memory request port as a held request carrying x, y, a write flag and write data. The request stays up until the memory acknowledges it. Read data from the memory is handed back to the host one cycle after the acknowledge. Only one pixel request is outstanding at a time. While it is pending, the block reports busy and ignores host accesses. The drawing registers are decoded into field outputs for the pixel engine and the display pipeline, which sit outside this block.

Top module: `vid_cursor_regif`

## Requirements
- R1: Reset clears the cursor, the destination line, the operation, colour and mode registers and the palette. After reset no frame request is pending and `host_busy` is low.
- R2: A read at offset 0x00 or 0x08 starts a frame read (`fp_we`=0) at the current cursor and leaves the cursor unchanged. `host_rdata` returns the frame data with `host_rvalid` high in the cycle after `fp_ack`.
- R3: A read at 0x02 or 0x0A first increments y and then reads at the new position. A read at 0x05 or 0x0D first increments x and then reads.
- R4: Writes below 0x10 move the cursor according to the low three offset bits: 1 loads x, 2 increments y, 3 loads x and increments y, 5 increments x, 6 loads y, 7 loads y and increments x, 0 holds. Loads take the low cursor-width bits of the bus data.
- R5: A write at 0x08–0x0B or 0x0D–0x0F issues one frame write at the cursor after its update. A write at 0x00–0x07 issues no frame access.
- R6: Frame-write data for offsets 0x09, 0x0B, 0x0E and 0x0F is the foreground colour repeated into every nibble. For 0x08, 0x0A and 0x0D it is the bus data.
- R7: Offsets 0x10 (destination line), 0x11 (operation), 0x12 (colour) and 0x13 (mode) are read/write registers. Colour bits 3:0 give the foreground and bits 7:4 the background. Operation bits 2:0 give the pixel width code and bit 3 the XOR flag. Mode bit 4 selects the 640-pixel mode and bits 3:0 give the border colour.
- R8: A write at 0x14+k loads palette bank k, which appears on `palette[16k+15:16k]`.
- R9: A read at 0x14 returns `scan_line` modulo 11, at 0x15 the x cursor and at 0x16 the y cursor. A register read returns with `host_rvalid` one cycle after it is accepted.
- R10: Reads at any other offset return zero. Writes at 0x04, 0x0C and 0x18–0x1F change no register and start no frame access.
- R11: Cursor increments wrap from 0xFFFF to 0x0000.
- R12: While a frame request is pending, `host_busy` is high and host accesses are ignored. The request holds its x, y, write flag and data stable until `fp_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, taken when not busy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 5 | Word offset |
| host_wdata | input | 16 | Host write data |
| host_busy | output | 1 | Frame request pending, accesses ignored |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | 16 | Read data |
| scan_line | input | 16 | Current display scan line |
| fp_req | output | 1 | Frame-memory request, held until acknowledged |
| fp_we | output | 1 | Frame request is a write |
| fp_x | output | 16 | Pixel x of request |
| fp_y | output | 16 | Pixel y of request |
| fp_wdata | output | 16 | Frame write data |
| fp_ack | input | 1 | Frame-memory acknowledge |
| fp_rdata | input | 16 | Frame read data, valid with fp_ack |
| dest_line | output | 16 | Destination line register |
| fg_colour | output | 4 | Foreground colour |
| bg_colour | output | 4 | Background colour |
| pix_width | output | 3 | Pixel width code |
| xor_draw | output | 1 | XOR drawing flag |
| hires_mode | output | 1 | 640-pixel mode flag |
| border_colour | output | 4 | Border colour |
| palette | output | 64 | Four palette banks, bank k at bits 16k+15:16k |

## Verification
The main stimulus is one walk through every cursor-moving offset in both directions. Each step starts from a distinct x and y, so a swapped axis, a missed pre-increment or an access issued before the cursor update shows up as a wrong request coordinate. Writes alternate between bus data and foreground fill so that a wrong fill set is caught. Offsets that share low bits but differ in bit 3 are paired, which separates cursor-only writes from drawing writes. Further cases cover the wrap at 0xFFFF, a slow acknowledge with a host write arriving while busy, unmapped offsets and the scan-line remainder.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

   localparam int unsigned OFS_W = 5;

   localparam logic [OFS_W-1:0] OFS_SCAN  = 5'h14;
   localparam logic [OFS_W-1:0] OFS_CUR_X = 5'h15;
   localparam logic [OFS_W-1:0] OFS_CUR_Y = 5'h16;

   localparam int unsigned CFG_REGS   = 4;
   localparam int unsigned MAX_BANKS  = 4;
   localparam int unsigned OPER_XOR_BIT = 3;
   localparam int unsigned MODE_HI_BIT  = 4;

   typedef enum logic [1:0] {
      CUR_HOLD = 2'd0,
      CUR_LOAD = 2'd1,
      CUR_INC  = 2'd2
   } cur_op_e;

   typedef enum logic [3:0] {
      RD_ZERO = 4'd0,
      RD_PIX  = 4'd1,
      RD_DEST = 4'd2,
      RD_OPER = 4'd3,
      RD_COL  = 4'd4,
      RD_MODE = 4'd5,
      RD_SCAN = 4'd6,
      RD_CX   = 4'd7,
      RD_CY   = 4'd8
   } rd_sel_e;

   typedef struct packed {
      cur_op_e                x_op;
      cur_op_e                y_op;
      logic                   pix_rd;
      logic                   pix_wr;
      logic                   fill;
      logic [CFG_REGS-1:0]    cfg_we;
      logic [MAX_BANKS-1:0]   pal_we;
      logic                   reg_rd;
      rd_sel_e                rd_sel;
   } acc_ctl_t;

endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
   import vcr_pkg::*;
(
   input  logic             acc,
   input  logic             we,
   input  logic [OFS_W-1:0] ofs,
   output acc_ctl_t         ctl
);

   logic [2:0] lo;
   logic       low_half;

   assign lo       = ofs[2:0];
   assign low_half = ~ofs[4];

   always_comb begin
      ctl = '0;
      if (acc && we) begin
         if (low_half && lo != 3'd4) begin
            case (lo)
               3'd1: ctl.x_op = CUR_LOAD;
               3'd2: ctl.y_op = CUR_INC;
               3'd3: begin
                  ctl.x_op = CUR_LOAD;
                  ctl.y_op = CUR_INC;
               end
               3'd5: ctl.x_op = CUR_INC;
               3'd6: ctl.y_op = CUR_LOAD;
               3'd7: begin
                  ctl.y_op = CUR_LOAD;
                  ctl.x_op = CUR_INC;
               end
               default: ;
            endcase
            ctl.pix_wr = ofs[3];
            ctl.fill   = ofs[3] && (lo == 3'd1 || lo == 3'd3 || lo == 3'd6 || lo == 3'd7);
         end else if (ofs[4:2] == 3'b100) begin
            ctl.cfg_we[ofs[1:0]] = 1'b1;
         end else if (ofs[4:2] == 3'b101) begin
            ctl.pal_we[ofs[1:0]] = 1'b1;
         end
      end else if (acc) begin
         if (low_half) begin
            case (lo)
               3'd0: ctl.pix_rd = 1'b1;
               3'd2: begin
                  ctl.y_op   = CUR_INC;
                  ctl.pix_rd = 1'b1;
               end
               3'd5: begin
                  ctl.x_op   = CUR_INC;
                  ctl.pix_rd = 1'b1;
               end
               default: ;
            endcase
            ctl.rd_sel = ctl.pix_rd ? RD_PIX : RD_ZERO;
         end else begin
            case (ofs)
               5'h10:     ctl.rd_sel = RD_DEST;
               5'h11:     ctl.rd_sel = RD_OPER;
               5'h12:     ctl.rd_sel = RD_COL;
               5'h13:     ctl.rd_sel = RD_MODE;
               OFS_SCAN:  ctl.rd_sel = RD_SCAN;
               OFS_CUR_X: ctl.rd_sel = RD_CX;
               OFS_CUR_Y: ctl.rd_sel = RD_CY;
               default:   ctl.rd_sel = RD_ZERO;
            endcase
         end
         ctl.reg_rd = ~ctl.pix_rd;
      end
   end

endmodule

// File: rtl/vcr_cursor.sv
module vcr_cursor
   import vcr_pkg::*;
#(
   parameter int unsigned CUR_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  cur_op_e               x_op,
   input  cur_op_e               y_op,
   input  logic [CUR_W-1:0]      load_val,
   output logic [1:0][CUR_W-1:0] cur_q,
   output logic [1:0][CUR_W-1:0] cur_nxt
);

   localparam int unsigned AXES = 2;

   cur_op_e ops [AXES];

   assign ops[0] = x_op;
   assign ops[1] = y_op;

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      always_comb begin
         case (ops[a])
            CUR_LOAD: cur_nxt[a] = load_val;
            CUR_INC:  cur_nxt[a] = cur_q[a] + CUR_W'(1);
            default:  cur_nxt[a] = cur_q[a];
         endcase
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cur_q[a] <= '0;
         else        cur_q[a] <= cur_nxt[a];
      end
   end

endmodule

// File: rtl/vcr_cfgregs.sv
module vcr_cfgregs
   import vcr_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PAL_BANKS = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [CFG_REGS-1:0]            cfg_we,
   input  logic [MAX_BANKS-1:0]           pal_we,
   input  logic [DATA_W-1:0]              wdata,
   output logic [CFG_REGS-1:0][DATA_W-1:0] cfg_q,
   output logic [PAL_BANKS*DATA_W-1:0]    pal_q
);

   for (genvar r = 0; r < CFG_REGS; r++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n)        cfg_q[r] <= '0;
         else if (cfg_we[r]) cfg_q[r] <= wdata;
      end
   end

   for (genvar b = 0; b < PAL_BANKS; b++) begin : g_pal
      always_ff @(posedge clk) begin
         if (!rst_n)         pal_q[b*DATA_W +: DATA_W] <= '0;
         else if (pal_we[b]) pal_q[b*DATA_W +: DATA_W] <= wdata;
      end
   end

   if (PAL_BANKS < MAX_BANKS) begin : g_pal_unused
      logic unused_we;
      assign unused_we = ^pal_we[MAX_BANKS-1:PAL_BANKS];
   end

endmodule

// File: rtl/vcr_pixreq.sv
module vcr_pixreq #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CUR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              launch_we,
   input  logic [CUR_W-1:0]  launch_x,
   input  logic [CUR_W-1:0]  launch_y,
   input  logic [DATA_W-1:0] launch_data,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_val,
   input  logic              fp_ack,
   input  logic [DATA_W-1:0] fp_rdata,
   output logic              fp_req,
   output logic              fp_we,
   output logic [CUR_W-1:0]  fp_x,
   output logic [CUR_W-1:0]  fp_y,
   output logic [DATA_W-1:0] fp_wdata,
   output logic              busy,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fp_req   <= 1'b0;
         fp_we    <= 1'b0;
         fp_x     <= '0;
         fp_y     <= '0;
         fp_wdata <= '0;
         rvalid   <= 1'b0;
         rdata    <= '0;
      end else begin
         rvalid <= 1'b0;
         if (launch) begin
            fp_req   <= 1'b1;
            fp_we    <= launch_we;
            fp_x     <= launch_x;
            fp_y     <= launch_y;
            fp_wdata <= launch_data;
         end else if (fp_req && fp_ack) begin
            fp_req <= 1'b0;
            if (!fp_we) begin
               rdata  <= fp_rdata;
               rvalid <= 1'b1;
            end
         end
         if (reg_rd) begin
            rdata  <= reg_val;
            rvalid <= 1'b1;
         end
      end
   end

   assign busy = fp_req;

endmodule

// File: rtl/vid_cursor_regif.sv
module vid_cursor_regif
   import vcr_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CUR_W     = 16,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned PAL_BANKS = 4,
   parameter int unsigned SCAN_W    = 16,
   parameter int unsigned SCAN_MOD  = 11
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_req,
   input  logic                        host_we,
   input  logic [OFS_W-1:0]            host_ofs,
   input  logic [DATA_W-1:0]           host_wdata,
   output logic                        host_busy,
   output logic                        host_rvalid,
   output logic [DATA_W-1:0]           host_rdata,
   input  logic [SCAN_W-1:0]           scan_line,
   output logic                        fp_req,
   output logic                        fp_we,
   output logic [CUR_W-1:0]            fp_x,
   output logic [CUR_W-1:0]            fp_y,
   output logic [DATA_W-1:0]           fp_wdata,
   input  logic                        fp_ack,
   input  logic [DATA_W-1:0]           fp_rdata,
   output logic [DATA_W-1:0]           dest_line,
   output logic [NIB_W-1:0]            fg_colour,
   output logic [NIB_W-1:0]            bg_colour,
   output logic [2:0]                  pix_width,
   output logic                        xor_draw,
   output logic                        hires_mode,
   output logic [NIB_W-1:0]            border_colour,
   output logic [PAL_BANKS*DATA_W-1:0] palette
);

   localparam int unsigned NIBS = DATA_W / NIB_W;

   if (DATA_W % NIB_W != 0) begin : g_chk_nib
      $error("DATA_W must be a multiple of NIB_W");
   end
   if (DATA_W < 2 * NIB_W || DATA_W <= MODE_HI_BIT) begin : g_chk_dw
      $error("DATA_W too narrow for the colour and mode fields");
   end
   if (CUR_W > DATA_W) begin : g_chk_cur
      $error("CUR_W must not exceed DATA_W");
   end
   if (PAL_BANKS < 1 || PAL_BANKS > MAX_BANKS) begin : g_chk_pal
      $error("PAL_BANKS out of range");
   end
   if (SCAN_MOD < 1) begin : g_chk_mod
      $error("SCAN_MOD must be non-zero");
   end

   acc_ctl_t                         ctl;
   logic                             acc;
   logic [1:0][CUR_W-1:0]            cur_q;
   logic [1:0][CUR_W-1:0]            cur_nxt;
   logic [CUR_W-1:0]                 cur_x;
   logic [CUR_W-1:0]                 cur_y;
   logic [CFG_REGS-1:0][DATA_W-1:0]  cfg_q;
   logic [DATA_W-1:0]                oper_q;
   logic [DATA_W-1:0]                colour_q;
   logic [DATA_W-1:0]                mode_q;
   logic [DATA_W-1:0]                fill_word;
   logic [DATA_W-1:0]                pix_data;
   logic [SCAN_W-1:0]                scan_rem;
   logic [DATA_W-1:0]                reg_val;

   assign acc = host_req & ~host_busy;

   vcr_decode u_decode (
      .acc (acc),
      .we  (host_we),
      .ofs (host_ofs),
      .ctl (ctl)
   );

   vcr_cursor #(.CUR_W(CUR_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .x_op     (ctl.x_op),
      .y_op     (ctl.y_op),
      .load_val (host_wdata[CUR_W-1:0]),
      .cur_q    (cur_q),
      .cur_nxt  (cur_nxt)
   );

   assign cur_x = cur_q[0];
   assign cur_y = cur_q[1];

   vcr_cfgregs #(.DATA_W(DATA_W), .PAL_BANKS(PAL_BANKS)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (ctl.cfg_we),
      .pal_we (ctl.pal_we),
      .wdata  (host_wdata),
      .cfg_q  (cfg_q),
      .pal_q  (palette)
   );

   assign dest_line = cfg_q[0];
   assign oper_q    = cfg_q[1];
   assign colour_q  = cfg_q[2];
   assign mode_q    = cfg_q[3];

   assign fg_colour     = colour_q[NIB_W-1:0];
   assign bg_colour     = colour_q[2*NIB_W-1:NIB_W];
   assign pix_width     = oper_q[2:0];
   assign xor_draw      = oper_q[OPER_XOR_BIT];
   assign hires_mode    = mode_q[MODE_HI_BIT];
   assign border_colour = mode_q[NIB_W-1:0];

   for (genvar n = 0; n < NIBS; n++) begin : g_fill
      assign fill_word[n*NIB_W +: NIB_W] = fg_colour;
   end

   assign pix_data = ctl.fill ? fill_word : host_wdata;
   assign scan_rem = scan_line % SCAN_W'(SCAN_MOD);

   always_comb begin
      case (ctl.rd_sel)
         RD_DEST: reg_val = dest_line;
         RD_OPER: reg_val = oper_q;
         RD_COL:  reg_val = colour_q;
         RD_MODE: reg_val = mode_q;
         RD_SCAN: reg_val = DATA_W'(scan_rem);
         RD_CX:   reg_val = DATA_W'(cur_x);
         RD_CY:   reg_val = DATA_W'(cur_y);
         default: reg_val = '0;
      endcase
   end

   vcr_pixreq #(.DATA_W(DATA_W), .CUR_W(CUR_W)) u_pixreq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (ctl.pix_rd | ctl.pix_wr),
      .launch_we   (ctl.pix_wr),
      .launch_x    (cur_nxt[0]),
      .launch_y    (cur_nxt[1]),
      .launch_data (pix_data),
      .reg_rd      (ctl.reg_rd),
      .reg_val     (reg_val),
      .fp_ack      (fp_ack),
      .fp_rdata    (fp_rdata),
      .fp_req      (fp_req),
      .fp_we       (fp_we),
      .fp_x        (fp_x),
      .fp_y        (fp_y),
      .fp_wdata    (fp_wdata),
      .busy        (host_busy),
      .rvalid      (host_rvalid),
      .rdata       (host_rdata)
   );

endmodule

// File: rtl/vid_cursor_regif_chk.sv
module vid_cursor_regif_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CUR_W  = 16,
   parameter int unsigned NIB_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_req,
   input logic              host_we,
   input logic [4:0]        host_ofs,
   input logic [DATA_W-1:0] host_wdata,
   input logic              host_busy,
   input logic              host_rvalid,
   input logic              fp_req,
   input logic              fp_we,
   input logic [CUR_W-1:0]  fp_x,
   input logic [CUR_W-1:0]  fp_y,
   input logic [DATA_W-1:0] fp_wdata,
   input logic              fp_ack,
   input logic [NIB_W-1:0]  fg_colour,
   input logic [CUR_W-1:0]  cur_x,
   input logic [CUR_W-1:0]  cur_y
);

   localparam int unsigned NIBS = DATA_W / NIB_W;

   logic acc;
   assign acc = host_req && !host_busy;

   p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fp_req && !fp_ack |=> fp_req && $stable(fp_x) && $stable(fp_y)
                            && $stable(fp_we) && $stable(fp_wdata));

   p_ignore_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      host_req && host_busy |=> $stable(cur_x) && $stable(cur_y));

   p_rd_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fp_req && fp_ack && !fp_we |=> host_rvalid);

   p_reg_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !host_we && host_ofs[4] |=> host_rvalid);

   p_xload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_we && host_ofs == 5'h01 |=> cur_x == $past(host_wdata[CUR_W-1:0]));

   p_yinc_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !host_we && host_ofs == 5'h02 |=> cur_y == CUR_W'($past(cur_y) + 1'b1));

   p_no_pix_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_we && !host_ofs[3] && !host_ofs[4] |=> !fp_req);

   p_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc && host_we && host_ofs == 5'h0E |=> fp_req && fp_we
                                              && fp_wdata == {NIBS{$past(fg_colour)}});

endmodule

bind vid_cursor_regif vid_cursor_regif_chk #(
   .DATA_W (DATA_W),
   .CUR_W  (CUR_W),
   .NIB_W  (NIB_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_req    (host_req),
   .host_we     (host_we),
   .host_ofs    (host_ofs),
   .host_wdata  (host_wdata),
   .host_busy   (host_busy),
   .host_rvalid (host_rvalid),
   .fp_req      (fp_req),
   .fp_we       (fp_we),
   .fp_x        (fp_x),
   .fp_y        (fp_y),
   .fp_wdata    (fp_wdata),
   .fp_ack      (fp_ack),
   .fg_colour   (fg_colour),
   .cur_x       (cur_x),
   .cur_y       (cur_y)
);

// File: tb/vid_cursor_regif_tb.sv
`timescale 1ns/1ps
module vid_cursor_regif_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0;
   logic        h_we = 1'b0;
   logic [4:0]  h_ofs = '0;
   logic [15:0] h_wd = '0;
   logic        h_busy, h_rvalid;
   logic [15:0] h_rd;
   logic [15:0] scan = '0;
   logic        fp_req, fp_we;
   logic [15:0] fp_x, fp_y, fp_wdata;
   logic        fp_ack = 1'b0;
   logic [15:0] fp_rdata = '0;
   logic [15:0] dest_line;
   logic [3:0]  fg, bg, border;
   logic [2:0]  pw;
   logic        xr, hi;
   logic [63:0] pal;

   always #2.5 clk = ~clk;

   vid_cursor_regif u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_req(h_req), .host_we(h_we), .host_ofs(h_ofs), .host_wdata(h_wd),
      .host_busy(h_busy), .host_rvalid(h_rvalid), .host_rdata(h_rd),
      .scan_line(scan),
      .fp_req(fp_req), .fp_we(fp_we), .fp_x(fp_x), .fp_y(fp_y), .fp_wdata(fp_wdata),
      .fp_ack(fp_ack), .fp_rdata(fp_rdata),
      .dest_line(dest_line), .fg_colour(fg), .bg_colour(bg), .pix_width(pw),
      .xor_draw(xr), .hires_mode(hi), .border_colour(border), .palette(pal)
   );

   int n_tests = 0;
   int n_fail  = 0;

   function automatic logic [15:0] pix_val(input logic [15:0] x, input logic [15:0] y);
      return x ^ {y[7:0], y[15:8]} ^ 16'hC3A5;
   endfunction

   // frame memory model
   int          lat = 0;
   int          cnt = 0;
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   logic [15:0] last_x = '0, last_y = '0, last_d = '0;

   always @(posedge clk) begin
      fp_ack <= 1'b0;
      if (fp_req && !fp_ack) begin
         if (cnt >= lat) begin
            cnt = 0;
            fp_ack <= 1'b1;
            last_x = fp_x;
            last_y = fp_y;
            if (fp_we) begin
               wr_cnt = wr_cnt + 1;
               last_d = fp_wdata;
            end else begin
               rd_cnt = rd_cnt + 1;
               fp_rdata <= pix_val(fp_x, fp_y);
            end
         end else begin
            cnt = cnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b1; h_ofs = a; h_wd = d;
      @(negedge clk);
      h_req = 1'b0; h_we = 1'b0;
      for (int i = 0; i < 100 && h_busy; i++) @(negedge clk);
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b0; h_ofs = a;
      @(negedge clk);
      h_req = 1'b0;
      for (int i = 0; i < 100 && !h_rvalid; i++) @(negedge clk);
      d = h_rvalid ? h_rd : 16'hDEAD;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // op: 0 write, no frame access; 1 write, frame write at (ex,ey) data ed;
   //     2 read, frame read at (ex,ey); 3 read, register value ed
   typedef struct packed {
      logic [1:0]  op;
      logic [4:0]  ofs;
      logic [15:0] wd;
      logic [15:0] ex;
      logic [15:0] ey;
      logic [15:0] ed;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 35;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 5'h12, 16'h00A3, 16'h0,    16'h0,    16'h0,    4'd7 },  // R7 colour fg=3
      '{2'd0, 5'h01, 16'h0010, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4 load x
      '{2'd0, 5'h06, 16'h0020, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4 load y
      '{2'd2, 5'h00, 16'h0,    16'h0010, 16'h0020, 16'h0,    4'd2 },  // R2
      '{2'd2, 5'h02, 16'h0,    16'h0010, 16'h0021, 16'h0,    4'd3 },  // R3 y pre-inc
      '{2'd2, 5'h05, 16'h0,    16'h0011, 16'h0021, 16'h0,    4'd3 },  // R3 x pre-inc
      '{2'd1, 5'h08, 16'h1234, 16'h0011, 16'h0021, 16'h1234, 4'd5 },  // R5
      '{2'd1, 5'h0A, 16'hBEEF, 16'h0011, 16'h0022, 16'hBEEF, 4'd5 },  // R5
      '{2'd1, 5'h0D, 16'h0F0F, 16'h0012, 16'h0022, 16'h0F0F, 4'd6 },  // R6 bus data
      '{2'd1, 5'h09, 16'h0040, 16'h0040, 16'h0022, 16'h3333, 4'd6 },  // R6 fill
      '{2'd1, 5'h0B, 16'h0050, 16'h0050, 16'h0023, 16'h3333, 4'd6 },  // R6 fill
      '{2'd1, 5'h0E, 16'h0060, 16'h0050, 16'h0060, 16'h3333, 4'd6 },  // R6 fill
      '{2'd1, 5'h0F, 16'h0070, 16'h0051, 16'h0070, 16'h3333, 4'd6 },  // R6 fill
      '{2'd0, 5'h03, 16'h0005, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4
      '{2'd3, 5'h15, 16'h0,    16'h0,    16'h0,    16'h0005, 4'd4 },  // R4 x
      '{2'd3, 5'h16, 16'h0,    16'h0,    16'h0,    16'h0071, 4'd4 },  // R4 y
      '{2'd0, 5'h07, 16'h0100, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4
      '{2'd0, 5'h02, 16'h7777, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4
      '{2'd0, 5'h05, 16'h7777, 16'h0,    16'h0,    16'h0,    4'd4 },  // R4
      '{2'd2, 5'h0A, 16'h0,    16'h0007, 16'h0102, 16'h0,    4'd3 },  // R3
      '{2'd2, 5'h0D, 16'h0,    16'h0008, 16'h0102, 16'h0,    4'd3 },  // R3
      '{2'd2, 5'h08, 16'h0,    16'h0008, 16'h0102, 16'h0,    4'd2 },  // R2
      '{2'd0, 5'h04, 16'h9999, 16'h0,    16'h0,    16'h0,    4'd10},  // R10
      '{2'd0, 5'h0C, 16'h9999, 16'h0,    16'h0,    16'h0,    4'd10},  // R10
      '{2'd3, 5'h15, 16'h0,    16'h0,    16'h0,    16'h0008, 4'd10},  // R10
      '{2'd3, 5'h16, 16'h0,    16'h0,    16'h0,    16'h0102, 4'd10},  // R10
      '{2'd0, 5'h10, 16'h0155, 16'h0,    16'h0,    16'h0,    4'd7 },  // R7
      '{2'd3, 5'h10, 16'h0,    16'h0,    16'h0,    16'h0155, 4'd7 },  // R7
      '{2'd0, 5'h11, 16'h000D, 16'h0,    16'h0,    16'h0,    4'd7 },  // R7
      '{2'd3, 5'h11, 16'h0,    16'h0,    16'h0,    16'h000D, 4'd7 },  // R7
      '{2'd0, 5'h13, 16'h0017, 16'h0,    16'h0,    16'h0,    4'd7 },  // R7
      '{2'd3, 5'h13, 16'h0,    16'h0,    16'h0,    16'h0017, 4'd7 },  // R7
      '{2'd3, 5'h12, 16'h0,    16'h0,    16'h0,    16'h00A3, 4'd7 },  // R7
      '{2'd3, 5'h01, 16'h0,    16'h0,    16'h0,    16'h0000, 4'd10},  // R10
      '{2'd3, 5'h1F, 16'h0,    16'h0,    16'h0,    16'h0000, 4'd10}   // R10
   };

   initial begin : watchdog
      #(200000 * 5);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin : main
      logic [15:0] rv;
      int          w0;
      string       tag;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", {15'd0, h_busy}, 16'd0);

      for (int i = 0; i < NV; i++) begin
         tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
         w0 = wr_cnt;
         case (VEC[i].op)
            2'd0: begin
               bus_wr(VEC[i].ofs, VEC[i].wd);
               chk({tag, " no frame write"}, 16'(wr_cnt - w0), 16'd0);
            end
            2'd1: begin
               bus_wr(VEC[i].ofs, VEC[i].wd);
               chk({tag, " write count"}, 16'(wr_cnt - w0), 16'd1);
               chk({tag, " x"}, last_x, VEC[i].ex);
               chk({tag, " y"}, last_y, VEC[i].ey);
               chk({tag, " data"}, last_d, VEC[i].ed);
            end
            2'd2: begin
               bus_rd(VEC[i].ofs, rv);
               chk({tag, " read data"}, rv, pix_val(VEC[i].ex, VEC[i].ey));
               chk({tag, " x"}, last_x, VEC[i].ex);
               chk({tag, " y"}, last_y, VEC[i].ey);
            end
            default: begin
               bus_rd(VEC[i].ofs, rv);
               chk({tag, " reg read"}, rv, VEC[i].ed);
            end
         endcase
      end

      // R7 field outputs
      chk("R7 fg", {12'd0, fg}, 16'h3);
      chk("R7 bg", {12'd0, bg}, 16'hA);
      chk("R7 width", {13'd0, pw}, 16'h5);
      chk("R7 xor", {15'd0, xr}, 16'h1);
      chk("R7 hires", {15'd0, hi}, 16'h1);
      chk("R7 border", {12'd0, border}, 16'h7);
      chk("R7 dest", dest_line, 16'h0155);

      // R8 palette banks
      bus_wr(5'h14, 16'h1234);
      bus_wr(5'h17, 16'hFEDC);
      chk("R8 bank0", pal[15:0], 16'h1234);
      chk("R8 bank3", pal[63:48], 16'hFEDC);
      chk("R8 bank1", pal[31:16], 16'h0000);

      // R9 scan remainder
      scan = 16'd25;
      bus_rd(5'h14, rv);
      chk("R9 scan 25", rv, 16'd3);
      scan = 16'd255;
      bus_rd(5'h14, rv);
      chk("R9 scan 255", rv, 16'd2);

      // R11 wrap
      bus_wr(5'h01, 16'hFFFF);
      bus_wr(5'h05, 16'h0);
      bus_rd(5'h15, rv);
      chk("R11 x wrap", rv, 16'h0000);
      bus_wr(5'h06, 16'hFFFF);
      bus_rd(5'h02, rv);
      chk("R11 y wrap read", rv, pix_val(16'h0, 16'h0));
      bus_rd(5'h16, rv);
      chk("R11 y wrap", rv, 16'h0000);

      // R10 unmapped write
      w0 = wr_cnt;
      bus_wr(5'h18, 16'hFFFF);
      bus_wr(5'h1B, 16'hFFFF);
      bus_rd(5'h10, rv);
      chk("R10 dest kept", rv, 16'h0155);
      bus_rd(5'h12, rv);
      chk("R10 colour kept", rv, 16'h00A3);
      chk("R10 no frame write", 16'(wr_cnt - w0), 16'd0);

      // R12 busy: slow acknowledge, host write while pending is ignored
      lat = 6;
      w0 = wr_cnt;
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b1; h_ofs = 5'h08; h_wd = 16'hAAAA;
      @(negedge clk);
      h_ofs = 5'h01; h_wd = 16'h4321;
      chk("R12 busy high", {15'd0, h_busy}, 16'd1);
      @(negedge clk);
      h_req = 1'b0; h_we = 1'b0;
      for (int i = 0; i < 100 && h_busy; i++) @(negedge clk);
      lat = 0;
      chk("R12 one write", 16'(wr_cnt - w0), 16'd1);
      chk("R12 write data", last_d, 16'hAAAA);
      bus_rd(5'h15, rv);
      chk("R12 x unchanged", rv, 16'h0000);

      // R1 reset clears registers
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 fp_req", {15'd0, fp_req}, 16'd0);
      chk("R1 palette", pal[15:0], 16'd0);
      bus_rd(5'h10, rv);
      chk("R1 dest", rv, 16'd0);
      bus_rd(5'h11, rv);
      chk("R1 oper", rv, 16'd0);
      bus_rd(5'h13, rv);
      chk("R1 mode", rv, 16'd0);
      bus_rd(5'h16, rv);
      chk("R1 y", rv, 16'd0);

      finish_run();
   end

endmodule